// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address for every beat of one read or write burst on a synchronous DRAM. A start strobe loads the first column, a burst-length code, an ordering select, the single-write mode bit and the direction of the access. From the following cycle on, the block presents one column per enabled clock and raises a last-beat flag on the final one.

Bursts of 1, 2, 4 or 8 beats stay inside an aligned block of that many columns and wrap at its edge. The low bits are either counted upward (sequential) or XORed with the beat number (interleaved), and the column bits above the block never change. A full-row burst counts upward through every column of the row and wraps around the row until a terminate strobe ends it. A terminate strobe can also cut short any fixed-length burst.

A new start may arrive in any enabled cycle and replaces the burst in progress. While the clock-suspend enable is low, the block holds its state and ignores its inputs.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset `valid`, `last` and `cfg_err` are 0.
- R2: With `order`=0 and `len_code` 0, 1, 2 or 3 (lengths 1, 2, 4, 8), beat i shows column (start_col with its low log2(len) bits replaced by (start_col + i) mod len).
- R3: With `order`=1 and the same length codes, beat i shows start_col with its low log2(len) bits replaced by (start_col XOR i) in those bits.
- R4: `len_code`=7 with `order`=0 is a full-row burst: beat i shows (start_col + i) mod 2^COL_W, it wraps past the row end, and `last` rises only on a terminate.
- R5: `last` is high exactly on the final beat of a fixed-length burst, and `valid` is 0 in the cycle after an enabled last beat unless a new start was accepted.
- R6: `stop` high in an enabled cycle with a burst in progress raises `last` in that same cycle and ends the burst at the next edge.
- R7: While `step_en` is 0 the column, beat position and `valid` hold, and `start` and `stop` have no effect.
- R8: `len_code` 4, 5 or 6, or `len_code`=7 with `order`=1, runs a burst of one beat and sets `cfg_err`, which stays 1 until reset.
- R9: An enabled `start` always begins a new burst on the next cycle with the column equal to `start_col`, even if a burst is in progress.
- R10: With `single_wr`=1, a write (`is_write`=1) is one beat whatever `len_code` is, while a read still follows `len_code` and `order`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Clock-suspend enable; 0 freezes the sequencer |
| start | input | 1 | Begin a burst with the inputs below |
| start_col | input | COL_W | First column of the burst |
| len_code | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 7:full row) |
| order | input | 1 | 0 sequential, 1 interleaved |
| single_wr | input | 1 | Writes are one beat when 1 |
| is_write | input | 1 | Direction of the access being started |
| stop | input | 1 | Burst terminate |
| col | output | COL_W | Column address of the current beat |
| valid | output | 1 | A burst beat is present |
| last | output | 1 | Current beat is the final one |
| cfg_err | output | 1 | Sticky flag for a reserved length/order setting |

## Verification
A start accepted at one rising edge shows its first column and `valid` right after that edge, and each later enabled edge moves one beat on, so beat i of a burst is due i+1 edges after the start. `last` on a terminate responds in the same cycle as `stop`, because it is combinational on that input, and `valid` falls one edge after an enabled last beat. The bench drives every input on the falling edge, waits a short delay, and compares the outputs once per cycle against its own arithmetic model. It checks each beat at exactly the cycle the sweep has reached, so any extra or missing register stage shifts the sequence and fails.

// File: rtl/sdram_col_seq.sv
module sdram_col_seq #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             order,
  input  logic             single_wr,
  input  logic             is_write,
  input  logic             stop,
  output logic [COL_W-1:0] col,
  output logic             valid,
  output logic             last,
  output logic             cfg_err
);
  localparam logic [COL_W-1:0] ROW_MASK = {COL_W{1'b1}};

  logic [COL_W-1:0] base_q, mask_q, beat_q;
  logic             full_q, inter_q;

  logic [COL_W-1:0] mask_n;
  logic             full_n, bad_n;

  always_comb begin
    mask_n = '0;
    full_n = 1'b0;
    bad_n  = 1'b0;
    case (len_code)
      3'd0: mask_n = '0;
      3'd1: mask_n = COL_W'(1);
      3'd2: mask_n = COL_W'(3);
      3'd3: mask_n = COL_W'(7);
      3'd7: begin
        mask_n = ROW_MASK;
        full_n = 1'b1;
        bad_n  = order;
      end
      default: bad_n = 1'b1;
    endcase
    if (bad_n || (single_wr && is_write)) begin
      mask_n = '0;
      full_n = 1'b0;
    end
  end

  logic [COL_W-1:0] low_bits;
  logic             final_beat;

  assign low_bits   = inter_q ? (base_q ^ beat_q) : (base_q + beat_q);
  assign col        = (base_q & ~mask_q) | (low_bits & mask_q);
  assign final_beat = !full_q && (beat_q == mask_q);
  assign last       = valid && (final_beat || (stop && step_en));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      mask_q  <= '0;
      beat_q  <= '0;
      full_q  <= 1'b0;
      inter_q <= 1'b0;
      valid   <= 1'b0;
      cfg_err <= 1'b0;
    end else if (step_en) begin
      if (start) begin
        base_q  <= start_col;
        mask_q  <= mask_n;
        full_q  <= full_n;
        inter_q <= order;
        beat_q  <= '0;
        valid   <= 1'b1;
        if (bad_n) cfg_err <= 1'b1;
      end else if (valid) begin
        if (last) valid <= 1'b0;
        else      beat_q <= beat_q + 1'b1;
      end
    end
  end
endmodule

module sdram_col_seq_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_en,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic [COL_W-1:0] col,
  input logic             valid,
  input logic             last,
  input logic             cfg_err
);
  assert_suspend_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(col) && $stable(valid));

  assert_last_in_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> valid);

  assert_end_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && last && !start |=> !valid);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  assert_restart_col_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && start |=> valid && (col == $past(start_col)));

  assert_keep_going_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && valid && !last && !start |=> valid);
endmodule

bind sdram_col_seq sdram_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_en(step_en), .start(start),
  .start_col(start_col), .col(col), .valid(valid), .last(last),
  .cfg_err(cfg_err)
);

// File: tb/tb_sdram_col_seq.sv
module tb_sdram_col_seq;
  localparam int CW = 6;
  localparam int ROW = 1 << CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_en = 1'b1, start = 1'b0, order = 1'b0, single_wr = 1'b0;
  logic is_write = 1'b0, stop = 1'b0;
  logic [CW-1:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic [CW-1:0] col;
  logic valid, last, cfg_err;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  sdram_col_seq #(.COL_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .start(start),
    .start_col(start_col), .len_code(len_code), .order(order),
    .single_wr(single_wr), .is_write(is_write), .stop(stop),
    .col(col), .valid(valid), .last(last), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int ecol(input int b, input int i, input int n, input bit il);
    int m = n - 1;
    return (b & ~m & (ROW - 1)) | ((il ? (b ^ i) : (b + i)) & m);
  endfunction

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 0; stop = 0; step_en = 1;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic launch(input int c, input int lc, input bit o, input bit w, input bit sw);
    @(negedge clk);
    start = 1; start_col = CW'(c); len_code = 3'(lc); order = o;
    is_write = w; single_wr = sw;
    tick();
    start = 0;
    #1;
  endtask

  task automatic run_burst(input string req, input int c, input int n, input bit o);
    for (int i = 0; i < n; i++) begin
      chk({req, " col"}, int'(col), ecol(c, i, n, o));
      chk({req, " last"}, int'(last), (i == n - 1) ? 1 : 0);
      chk({req, " valid"}, int'(valid), 1);
      tick();
    end
    chk({req, " end"}, int'(valid), 0);
  endtask

  initial begin
    do_reset();
    #1;
    chk("R1 valid", int'(valid), 0);
    chk("R1 last", int'(last), 0);
    chk("R1 err", int'(cfg_err), 0);

    for (int o = 0; o < 2; o++)
      for (int lc = 0; lc < 4; lc++)
        for (int s = 0; s < ROW; s++) begin
          launch(s, lc, o[0], 0, 0);
          run_burst(o ? "R3" : "R2", s, 1 << lc, o[0]);
        end
    chk("R5 no err", int'(cfg_err), 0);

    launch(37, 7, 0, 0, 0);
    for (int i = 0; i < 70; i++) begin
      chk("R4 col", int'(col), (37 + i) % ROW);
      chk("R4 last", int'(last), 0);
      tick();
    end
    stop = 1; #1;
    chk("R4 stop last", int'(last), 1);
    chk("R4 stop col", int'(col), (37 + 70) % ROW);
    tick(); stop = 0; #1;
    chk("R4 end", int'(valid), 0);

    launch(10, 3, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      chk("R6 col", int'(col), ecol(10, i, 8, 0));
      chk("R6 last", int'(last), 0);
      tick();
    end
    stop = 1; #1;
    chk("R6 last on stop", int'(last), 1);
    tick(); stop = 0; #1;
    chk("R6 end", int'(valid), 0);

    launch(5, 3, 1, 0, 0);
    tick(); tick();
    step_en = 0; start = 1; start_col = CW'(50); stop = 1; #1;
    for (int k = 0; k < 3; k++) begin
      chk("R7 hold col", int'(col), ecol(5, 2, 8, 1));
      chk("R7 hold valid", int'(valid), 1);
      tick();
    end
    step_en = 1; start = 0; stop = 0; #1;
    for (int i = 2; i < 8; i++) begin
      chk("R7 resume col", int'(col), ecol(5, i, 8, 1));
      chk("R7 resume last", int'(last), (i == 7) ? 1 : 0);
      tick();
    end
    chk("R7 end", int'(valid), 0);

    launch(20, 3, 0, 0, 0);
    tick(); tick();
    launch(40, 2, 1, 0, 0);
    run_burst("R9", 40, 4, 1);

    launch(27, 3, 0, 1, 1);
    run_burst("R10 write single", 27, 1, 0);
    launch(27, 2, 0, 0, 1);
    run_burst("R10 read burst", 27, 4, 0);
    launch(27, 1, 1, 1, 0);
    run_burst("R10 write normal", 27, 2, 1);

    for (int lc = 4; lc < 7; lc++) begin
      do_reset(); #1;
      chk("R8 clear", int'(cfg_err), 0);
      launch(13, lc, 0, 0, 0);
      chk("R8 err", int'(cfg_err), 1);
      run_burst("R8 reserved", 13, 1, 0);
    end
    launch(44, 2, 0, 0, 0);
    run_burst("R8 legal after", 44, 4, 0);
    chk("R8 sticky", int'(cfg_err), 1);
    do_reset(); #1;
    chk("R8 reset clear", int'(cfg_err), 0);
    launch(13, 7, 1, 0, 0);
    chk("R8 full interleaved err", int'(cfg_err), 1);
    run_burst("R8 full interleaved", 13, 1, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule